// File: doc/BRIEF.md
# Branch Target Stream Cache

This block is a small set-associative store that sits beside a fetch unit. When a taken branch resolves, the fetch logic writes the target address and the first two instruction words of the target stream into it. A later fetch to the same target address finds those two words here, one cycle after presenting the address. The fetch unit can then fill its instruction queue a cycle earlier than the instruction cache could.

There are 16 sets of 4 ways, which gives 64 entries. Each entry holds a valid bit, a tag and two instruction words. A lookup reads the storage as it stood before the clock edge and registers the result. An allocation writes at the same edge. It overwrites a way that already holds the address. Otherwise it fills the lowest-numbered empty way, and if the set is full it evicts the way that a 3-bit tree pseudo-LRU names. A single strobe empties the whole store in one cycle.

Top module: `tgt_stream_cache`

## Requirements
- R1: After reset every entry is invalid, and `hit`, `hitInsn0` and `hitInsn1` are 0.
- R2: The result of a lookup appears on `hit`, `hitInsn0` and `hitInsn1` in the cycle after `lkValid` is sampled high. In the cycle after `lkValid` is sampled low, all three outputs are 0.
- R3: The set index is address bits [5:2] and the tag is bits [31:6]. Address bits [1:0] have no effect on lookup or allocation.
- R4: On a hit, `hitInsn0` and `hitInsn1` carry the two words stored with that address. On a miss, `hit` is 0 and both words are 0.
- R5: Allocating an address that is already valid in its set overwrites that way. No second copy of the address is created.
- R6: When the address is not present, allocation fills the lowest-numbered invalid way of the set. If all four ways are valid, it uses the pseudo-LRU victim.
- R7: Each set has a 3-bit tree: bit0 chooses between ways {0,1} (0) and ways {2,3} (1), bit1 chooses way 0 or way 1, and bit2 chooses way 2 or way 3. The victim follows the bits from bit0 downward. Using a way sets the bits on its path to point away from it. A hit is applied first, then an allocation in the same cycle chooses its victim from the result and applies its own update. All bits are 0 after reset, and invalidation leaves them unchanged.
- R8: A set holds at most four distinct tags. Allocating a fifth tag removes exactly the victim way, and the other three ways still hit.
- R9: `invAll` clears every valid bit at one clock edge. An allocation presented in the same cycle is dropped, and any lookup from the next cycle on misses.
- R10: A lookup and an allocation in the same cycle leave the lookup with the contents from before the edge. The new entry is visible to a lookup presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Lookup target address |
| alValid | input | 1 | Allocate/update request from a resolved taken branch |
| alAddr | input | 32 | Target address to allocate |
| alInsn0 | input | 32 | First instruction word of the target stream |
| alInsn1 | input | 32 | Second instruction word of the target stream |
| invAll | input | 1 | Invalidate every entry |
| hit | output | 1 | Registered lookup hit |
| hitInsn0 | output | 32 | First target word on a hit, otherwise 0 |
| hitInsn1 | output | 32 | Second target word on a hit, otherwise 0 |

## Verification
The assertions assume that the inputs are driven to known values whenever reset is released. They also assume that `invAll` and `alValid` are low during reset, so the first `$past` samples after reset mean something. The bench drives every input from its tasks at the falling edge, holds them all at zero through reset, and draws addresses from a pool of six tags across the sixteen sets. This pool forces repeated hits, overwrites and evictions while the alignment bits [1:0] stay random.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef struct packed {
    logic wrEn;
    logic clrAll;
    logic capture;
  } tscStrobe_t;

  function automatic int unsigned plruVictim(input logic [63:0] tree, input int unsigned ways);
    int unsigned node;
    node = 0;
    for (int lvl = 0; lvl < 6; lvl++) begin
      if (node < ways - 1) node = 2 * node + 1 + int'(tree[node]);
    end
    return node - (ways - 1);
  endfunction

  function automatic logic [63:0] plruTouch(input logic [63:0] tree, input int unsigned way,
                                            input int unsigned ways);
    int unsigned node;
    int unsigned levels;
    logic [63:0] res;
    res = tree;
    node = 0;
    levels = $clog2(ways);
    for (int lvl = 5; lvl >= 0; lvl--) begin
      if (lvl < int'(levels)) begin
        res[node] = ~way[lvl];
        node = 2 * node + 1 + int'(way[lvl]);
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/tsc_store.sv
module tsc_store
  import tsc_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tscStrobe_t        strobe,
  input  logic [WAYS-1:0]   wrWayOh,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [ADDR_W-1:0] alAddr,
  input  logic [INSN_W-1:0] alInsn0,
  input  logic [INSN_W-1:0] alInsn1,
  output logic [WAYS-1:0]   lkMatch,
  output logic [WAYS-1:0]   alMatch,
  output logic [WAYS-1:0]   alValidVec,
  output logic              hitQ,
  output logic [INSN_W-1:0] insn0Q,
  output logic [INSN_W-1:0] insn1Q
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - SET_W - 2;

  logic [SETS-1:0][WAYS-1:0] validMem;
  logic [TAG_W-1:0]  tagMem  [SETS][WAYS];
  logic [INSN_W-1:0] word0Mem[SETS][WAYS];
  logic [INSN_W-1:0] word1Mem[SETS][WAYS];

  logic [SET_W-1:0] lkSet, alSet;
  logic [TAG_W-1:0] lkTag, alTag;
  logic [INSN_W-1:0] rd0, rd1;

  assign lkSet = lkAddr[SET_W+1:2];
  assign alSet = alAddr[SET_W+1:2];
  assign lkTag = lkAddr[ADDR_W-1:SET_W+2];
  assign alTag = alAddr[ADDR_W-1:SET_W+2];
  assign alValidVec = validMem[alSet];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lkMatch[w] = validMem[lkSet][w] && (tagMem[lkSet][w] == lkTag);
    assign alMatch[w] = validMem[alSet][w] && (tagMem[alSet][w] == alTag);
  end

  always_comb begin
    rd0 = '0;
    rd1 = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lkMatch[w]) begin
        rd0 = rd0 | word0Mem[lkSet][w];
        rd1 = rd1 | word1Mem[lkSet][w];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMem <= '0;
    end else if (strobe.clrAll) begin
      validMem <= '0;
    end else if (strobe.wrEn) begin
      validMem[alSet] <= validMem[alSet] | wrWayOh;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      for (int w = 0; w < WAYS; w++) begin
        if (wrWayOh[w]) begin
          tagMem[alSet][w]   <= alTag;
          word0Mem[alSet][w] <= alInsn0;
          word1Mem[alSet][w] <= alInsn1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ   <= 1'b0;
      insn0Q <= '0;
      insn1Q <= '0;
    end else begin
      hitQ   <= strobe.capture && (|lkMatch);
      insn0Q <= strobe.capture ? rd0 : '0;
      insn1Q <= strobe.capture ? rd1 : '0;
    end
  end

  // R5: the overwrite rule keeps every address in at most one way of its set
  a_r5_single_copy_lookup: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatch));
  a_r5_single_copy_alloc: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(alMatch));

endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lkValid,
  input  logic                     alValid,
  input  logic                     invAll,
  input  logic [$clog2(SETS)-1:0]  lkSet,
  input  logic [$clog2(SETS)-1:0]  alSet,
  input  logic [WAYS-1:0]          lkMatch,
  input  logic [WAYS-1:0]          alMatch,
  input  logic [WAYS-1:0]          alValidVec,
  output tscStrobe_t               strobe,
  output logic [WAYS-1:0]          wrWayOh
);
  localparam int TREE_W = WAYS - 1;
  localparam int WAY_W  = $clog2(WAYS);

  logic [SETS-1:0][TREE_W-1:0] plruMem;

  logic              lkHit;
  logic [WAY_W-1:0]  lkWay, alWay, matchWay, freeWay;
  logic [TREE_W-1:0] lkTreeNew, alBase, alTreeNew;
  logic [63:0]       tmpLk, tmpAl;

  always_comb begin
    lkHit = lkValid && (|lkMatch);
    lkWay = '0;
    matchWay = '0;
    freeWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lkMatch[w]) lkWay = WAY_W'(w);
      if (alMatch[w]) matchWay = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!alValidVec[w]) freeWay = WAY_W'(w);
    end
    tmpLk = plruTouch(64'(plruMem[lkSet]), int'(lkWay), WAYS);
    lkTreeNew = tmpLk[TREE_W-1:0];
    alBase = (lkHit && (lkSet == alSet)) ? lkTreeNew : plruMem[alSet];
    if (|alMatch)             alWay = matchWay;
    else if (!(&alValidVec))  alWay = freeWay;
    else                      alWay = WAY_W'(plruVictim(64'(alBase), WAYS));
    tmpAl = plruTouch(64'(alBase), int'(alWay), WAYS);
    alTreeNew = tmpAl[TREE_W-1:0];
    wrWayOh = '0;
    wrWayOh[alWay] = 1'b1;
    strobe.wrEn    = alValid && !invAll;
    strobe.clrAll  = invAll;
    strobe.capture = lkValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      plruMem <= '0;
    end else begin
      if (lkHit)       plruMem[lkSet] <= lkTreeNew;
      if (strobe.wrEn) plruMem[alSet] <= alTreeNew;
    end
  end

  // R6: a write selects exactly one way
  a_r6_one_way: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> $onehot(wrWayOh));
  // R6: with a free way present and no match, no valid way is overwritten
  a_r6_fill_free_first: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !(|alMatch) && !(&alValidVec)) |-> ((wrWayOh & alValidVec) == '0));
  // R5: a matching way is always the one rewritten
  a_r5_rewrite_match: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && (|alMatch)) |-> (wrWayOh == alMatch));

endmodule

// File: rtl/tgt_stream_cache.sv
module tgt_stream_cache
  import tsc_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              alValid,
  input  logic [ADDR_W-1:0] alAddr,
  input  logic [INSN_W-1:0] alInsn0,
  input  logic [INSN_W-1:0] alInsn1,
  input  logic              invAll,
  output logic              hit,
  output logic [INSN_W-1:0] hitInsn0,
  output logic [INSN_W-1:0] hitInsn1
);
  localparam int SET_W = $clog2(SETS);

  tscStrobe_t       strobe;
  logic [WAYS-1:0]  wrWayOh, lkMatch, alMatch, alValidVec;

  tsc_ctrl #(.SETS(SETS), .WAYS(WAYS)) u_ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .alValid(alValid), .invAll(invAll),
    .lkSet(lkAddr[SET_W+1:2]), .alSet(alAddr[SET_W+1:2]),
    .lkMatch(lkMatch), .alMatch(alMatch), .alValidVec(alValidVec),
    .strobe(strobe), .wrWayOh(wrWayOh)
  );

  tsc_store #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrWayOh(wrWayOh),
    .lkAddr(lkAddr), .alAddr(alAddr), .alInsn0(alInsn0), .alInsn1(alInsn1),
    .lkMatch(lkMatch), .alMatch(alMatch), .alValidVec(alValidVec),
    .hitQ(hit), .insn0Q(hitInsn0), .insn1Q(hitInsn1)
  );

  // R2: no request, no hit
  a_r2_idle_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !hit);
  // R9: a lookup right after invalidation misses
  a_r9_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && $past(invAll)) |=> !hit);
  // R10: an entry written at the previous edge is visible
  a_r10_visible_next: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !invAll && $past(alValid && !invAll) &&
     (lkAddr[ADDR_W-1:2] == $past(alAddr[ADDR_W-1:2]))) |=> hit);
  // R4: a miss carries zero words
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (hitInsn0 == '0 && hitInsn1 == '0));

endmodule

// File: tb/tgt_stream_cache_bench.sv
`timescale 1ns/1ps
module tgt_stream_cache_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 1'b0, alValid = 1'b0, invAll = 1'b0;
  logic [31:0] lkAddr = '0, alAddr = '0, alInsn0 = '0, alInsn1 = '0;
  logic hit;
  logic [31:0] hitInsn0, hitInsn1;

  always #2.5 clk = ~clk;

  tgt_stream_cache u_tgt_stream_cache (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAddr(lkAddr),
    .alValid(alValid), .alAddr(alAddr), .alInsn0(alInsn0), .alInsn1(alInsn1),
    .invAll(invAll), .hit(hit), .hitInsn0(hitInsn0), .hitInsn1(hitInsn1)
  );

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  bit          mValid[16][4];
  logic [25:0] mTag[16][4];
  logic [31:0] mW0[16][4];
  logic [31:0] mW1[16][4];
  logic [2:0]  mTree[16];

  bit          expHit = 0;
  logic [31:0] expI0 = '0, expI1 = '0;
  string       expTag = "R1";

  function automatic int victimOf(input logic [2:0] t);
    if (!t[0]) return t[1] ? 1 : 0;
    return t[2] ? 3 : 2;
  endfunction

  function automatic logic [2:0] touchOf(input logic [2:0] t, input int w);
    logic [2:0] r = t;
    case (w)
      0: begin r[0] = 1'b1; r[1] = 1'b1; end
      1: begin r[0] = 1'b1; r[1] = 1'b0; end
      2: begin r[0] = 1'b0; r[2] = 1'b1; end
      default: begin r[0] = 1'b0; r[2] = 1'b0; end
    endcase
    return r;
  endfunction

  task automatic compareNow();
    vectors++;
    if (hit !== expHit || hitInsn0 !== expI0 || hitInsn1 !== expI1) begin
      fails++;
      $display("FAIL %s: hit/insn0/insn1 got %0b/%h/%h expected %0b/%h/%h",
               expTag, hit, hitInsn0, hitInsn1, expHit, expI0, expI1);
    end
  endtask

  task automatic step(input bit lk, input logic [31:0] la, input bit al,
                      input logic [31:0] aa, input logic [31:0] d0,
                      input logic [31:0] d1, input bit inv, input string tag);
    int ls, as, hw, aw;
    @(negedge clk);
    compareNow();
    ls = int'(la[5:2]);
    as = int'(aa[5:2]);
    hw = -1;
    for (int w = 0; w < 4; w++) if (mValid[ls][w] && mTag[ls][w] == la[31:6]) hw = w;
    expTag = tag;
    expHit = lk && (hw >= 0);
    expI0  = expHit ? mW0[ls][hw] : '0;
    expI1  = expHit ? mW1[ls][hw] : '0;
    if (expHit) mTree[ls] = touchOf(mTree[ls], hw);
    if (inv) begin
      for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) mValid[s][w] = 0;
    end else if (al) begin
      aw = -1;
      for (int w = 0; w < 4; w++) if (mValid[as][w] && mTag[as][w] == aa[31:6]) aw = w;
      if (aw < 0) for (int w = 3; w >= 0; w--) if (!mValid[as][w]) aw = w;
      if (aw < 0) aw = victimOf(mTree[as]);
      mValid[as][aw] = 1;
      mTag[as][aw] = aa[31:6];
      mW0[as][aw] = d0;
      mW1[as][aw] = d1;
      mTree[as] = touchOf(mTree[as], aw);
    end
    lkValid = lk; lkAddr = la; alValid = al; alAddr = aa;
    alInsn0 = d0; alInsn1 = d1; invAll = inv;
  endtask

  function automatic logic [31:0] mk(input int tg, input int st, input int lo);
    return {26'(tg), 4'(st), 2'(lo)};
  endfunction

  task automatic look(input logic [31:0] a, input string tag);
    step(1, a, 0, '0, '0, '0, 0, tag);
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d0, input string tag);
    step(0, '0, 1, a, d0, ~d0, 0, tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < 16; s++) begin
      mTree[s] = '0;
      for (int w = 0; w < 4; w++) mValid[s][w] = 0;
    end
    repeat (3) @(negedge clk);
    vectors++;
    if (hit !== 1'b0 || hitInsn0 !== '0 || hitInsn1 !== '0) begin
      fails++;
      $display("FAIL R1: outputs in reset got %0b/%h/%h expected 0/0/0", hit, hitInsn0, hitInsn1);
    end
    rstN = 1'b1;

    // R1: empty after reset
    look(mk(1, 3, 0), "R1");
    look(mk(0, 0, 0), "R1");
    // R10: same-cycle lookup sees old contents, next cycle sees the write
    step(1, mk(7, 3, 0), 1, mk(7, 3, 0), 32'hA0A0_0001, 32'hB0B0_0001, 0, "R10");
    look(mk(7, 3, 0), "R10");
    // R4: stored words returned
    look(mk(7, 3, 0), "R4");
    step(0, mk(7, 3, 0), 0, '0, '0, '0, 0, "R2");
    // R3: low bits ignored, other tag in same set misses
    look(mk(7, 3, 3), "R3");
    look(mk(8, 3, 1), "R3");
    look(mk(7, 4, 0), "R3");
    // R5: overwrite in place
    put(mk(7, 3, 2), 32'hC0DE_0002, "R5");
    look(mk(7, 3, 0), "R5");
    // R6: fill remaining ways, R8: fifth tag evicts victim
    put(mk(9, 3, 0), 32'h0000_0009, "R6");
    put(mk(10, 3, 0), 32'h0000_000A, "R6");
    put(mk(11, 3, 0), 32'h0000_000B, "R6");
    look(mk(9, 3, 0), "R7");
    look(mk(7, 3, 0), "R7");
    put(mk(12, 3, 0), 32'h0000_000C, "R8");
    for (int t = 7; t <= 12; t++) look(mk(t, 3, 0), "R8");
    // R7: hit and allocation in the same set in one cycle
    step(1, mk(12, 3, 0), 1, mk(13, 3, 0), 32'h0000_000D, 32'h1111_000D, 0, "R7");
    for (int t = 7; t <= 13; t++) look(mk(t, 3, 0), "R7");
    // R9: invalidate drops concurrent allocation
    step(1, mk(13, 3, 0), 1, mk(14, 5, 0), 32'h0E0E_0E0E, 32'h1, 1, "R9");
    look(mk(13, 3, 0), "R9");
    look(mk(14, 5, 0), "R9");
    look(mk(12, 3, 0), "R9");

    // random mix over a small tag pool
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit lk, al, inv;
      r = int'($urandom % 100);
      lk = (r < 70);
      al = (int'($urandom % 100) < 40);
      inv = (int'($urandom % 300) == 0);
      step(lk, mk(int'($urandom % 6), int'($urandom % 16), int'($urandom % 4)),
           al, mk(int'($urandom % 6), int'($urandom % 16), int'($urandom % 4)),
           $urandom, $urandom, inv, "R7/R6/R4");
    end
    step(0, '0, 0, '0, '0, '0, 0, "R2");
    @(negedge clk);
    compareNow();
    finish();
  end
endmodule